// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block walks a bit array that holds one control flag for every stream and channel position of a time-division frame, and sends those flags out on one serial pin. A frame has 16 streams and 32 channel slots. Each slot lasts 16 bit clocks, so the pin carries one flag per clock, one for each stream. The flags are sent one slot early: the slot just before channel k carries the flags of channel k for streams 0 through 15, in that order. The last slot of a frame therefore carries the channel 0 flags of the next frame.

A frame start pulse aligns an internal clock counter. The block drives a read address into the external flag array, which answers combinationally, and registers the returned bit onto the pin. The pin stays low from reset until the first frame pulse has been seen.

Top module: `ctrl_bit_serializer`

## Requirements
- R1: After reset and until the first frame pulse has been sampled, `ctrl_o` is low whatever the array holds.
- R2: Once the block is aligned, `ctrl_o` in each clock period equals the value that `rd_data_i` had in the previous period, i.e. the flag at the location addressed one clock earlier, unchanged in polarity.
- R3: In the clock period after a rising edge that samples `frame_i` high, the frame position is 0 (slot 0, stream 0), so `rd_addr_o` reads location 1 (stream 0, channel 1).
- R4: Location addresses are stream*32 + channel: bits [8:5] hold the stream and bits [4:0] hold the channel. Frame position p (clocks since the frame pulse) reads stream p mod 16 and channel (p/16 + 1) mod 32. Within a slot the stream steps 0 to 15 and the channel stays fixed.
- R5: The flags of channel 0 are sent in slot 31. Location 0 (stream 0, channel 0) is read at position 496, the first clock of slot 31, and location 32 (stream 1, channel 0) at position 497. Location 511 (position 495) is followed by location 0.
- R6: Without a new frame pulse, the position wraps from 511 to 0 and the same 512-clock sequence repeats. After location 480 (position 511) comes location 1.
- R7: A frame pulse that arrives in the middle of a frame restarts the sequence at position 0 in the next period. The pin keeps carrying the flag read in the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock of the serial streams |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame start pulse, one clock wide |
| rd_data_i | input | 1 | Flag read from the array at `rd_addr_o` (combinational) |
| rd_addr_o | output | 9 | Array location being read, stream*32 + channel |
| ctrl_o | output | 1 | Serial control pin |

## Verification
The array is filled with all zeros, all ones, a pattern that alternates with the stream index, and random contents. Constant fills show only whether the polarity is right and whether the pin is forced low. The stream-alternating fill shows whether the flags are interleaved across streams inside a slot. Random fills show any error in the channel lead or in the address arithmetic. Frames run back to back without pulses to test the wrap, and a pulse at a random point mid-frame tests realignment.

// File: rtl/ctrl_ser_pkg.sv
package ctrl_ser_pkg;
    localparam int unsigned DEF_STREAMS  = 16;
    localparam int unsigned DEF_CHANNELS = 32;
endpackage

// File: rtl/ctrl_ser_timer.sv
module ctrl_ser_timer #(
    parameter int unsigned STREAMS  = ctrl_ser_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctrl_ser_pkg::DEF_CHANNELS,
    localparam int unsigned CW      = $clog2(STREAMS * CHANNELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    output logic [CW-1:0] pos_o,
    output logic          synced_o
);
    localparam logic [CW-1:0] LAST_POS = CW'(STREAMS * CHANNELS - 1);

    typedef struct packed {
        logic [CW-1:0] pos;
        logic          synced;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_i) begin
            st_d.pos    = '0;
            st_d.synced = 1'b1;
        end else if (st_q.synced) begin
            st_d.pos = (st_q.pos == LAST_POS) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o    = st_q.pos;
    assign synced_o = st_q.synced;
endmodule

// File: rtl/ctrl_ser_mapper.sv
module ctrl_ser_mapper #(
    parameter int unsigned STREAMS  = ctrl_ser_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctrl_ser_pkg::DEF_CHANNELS,
    localparam int unsigned CW      = $clog2(STREAMS * CHANNELS),
    localparam int unsigned SW      = $clog2(STREAMS),
    localparam int unsigned HW      = $clog2(CHANNELS)
) (
    input  logic [CW-1:0] pos_i,
    output logic [CW-1:0] addr_o
);
    localparam logic [CW-1:0] STREAMS_C  = CW'(STREAMS);
    localparam logic [CW-1:0] CHANNELS_C = CW'(CHANNELS);
    localparam logic [HW-1:0] LAST_CH    = HW'(CHANNELS - 1);

    logic [SW-1:0] stream;
    logic [HW-1:0] slot;
    logic [HW-1:0] chan;

    always_comb begin
        stream = SW'(pos_i % STREAMS_C);
        slot   = HW'(pos_i / STREAMS_C);
        chan   = (slot == LAST_CH) ? '0 : slot + 1'b1;
        addr_o = CW'(stream) * CHANNELS_C + CW'(chan);
    end
endmodule

// File: rtl/ctrl_bit_serializer.sv
module ctrl_bit_serializer #(
    parameter int unsigned STREAMS  = ctrl_ser_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctrl_ser_pkg::DEF_CHANNELS,
    localparam int unsigned AW      = $clog2(STREAMS * CHANNELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          ctrl_o
);
    typedef struct packed {
        logic ctrl;
    } out_t;

    logic [AW-1:0] pos;
    logic          synced;
    out_t          out_d, out_q;

    ctrl_ser_timer #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame_i),
        .pos_o    (pos),
        .synced_o (synced)
    );

    ctrl_ser_mapper #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_mapper (
        .pos_i  (pos),
        .addr_o (rd_addr_o)
    );

    always_comb begin
        out_d      = out_q;
        out_d.ctrl = synced ? rd_data_i : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ctrl_o = out_q.ctrl;
endmodule

// File: rtl/ctrl_ser_chk.sv
module ctrl_ser_chk #(
    parameter int unsigned STREAMS  = ctrl_ser_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctrl_ser_pkg::DEF_CHANNELS,
    localparam int unsigned AW      = $clog2(STREAMS * CHANNELS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_i,
    input logic          rd_data_i,
    input logic [AW-1:0] rd_addr_o,
    input logic          ctrl_o
);
    localparam logic [AW-1:0] CH_C      = AW'(CHANNELS);
    localparam logic [AW-1:0] LAST_ST   = AW'(STREAMS - 1);
    localparam logic [AW-1:0] LAST_CH   = AW'(CHANNELS - 1);
    localparam logic [AW-1:0] LAST_LOC  = AW'(STREAMS * CHANNELS - 1);
    localparam logic [AW-1:0] FRAME_END = AW'((STREAMS - 1) * CHANNELS);

    logic          seen_q;
    logic [AW-1:0] cur_st, cur_ch, exp_next;

    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (frame_i) seen_q <= 1'b1;
    end

    always_comb begin
        cur_st = rd_addr_o / CH_C;
        cur_ch = rd_addr_o % CH_C;
        if (cur_st != LAST_ST)
            exp_next = (cur_st + 1'b1) * CH_C + cur_ch;
        else
            exp_next = (cur_ch == LAST_CH) ? '0 : cur_ch + 1'b1;
    end

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !ctrl_o);

    assert_pin_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> (ctrl_o == $past(rd_data_i)));

    // also covers R7: a mid-frame pulse restarts the same way
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (rd_addr_o == AW'(1)));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !frame_i) |=> (rd_addr_o == $past(exp_next)));

    assert_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !frame_i && rd_addr_o == LAST_LOC) |=> (rd_addr_o == '0));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !frame_i && rd_addr_o == FRAME_END) |=> (rd_addr_o == AW'(1)));
endmodule

bind ctrl_bit_serializer ctrl_ser_chk #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_chk (.*);

// File: tb/tb_ctrl_bit_serializer.sv
`timescale 1ns/1ps
module tb_ctrl_bit_serializer;
    localparam int NLOC = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_i = 1'b0;
    logic       rd_data_i;
    logic [8:0] rd_addr_o;
    logic       ctrl_o;

    logic       mem [NLOC];
    int         compared = 0;
    int         mismatched = 0;
    bit         done = 0;
    bit         synced = 0;
    int         pos = 0;
    string      addr_tag = "R4";

    always #2.5 clk = ~clk;

    assign rd_data_i = mem[rd_addr_o];

    ctrl_bit_serializer dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
        .rd_data_i(rd_data_i), .rd_addr_o(rd_addr_o), .ctrl_o(ctrl_o)
    );

    function automatic int addr_of(input int p);
        int st, sl, ch;
        st = p % 16;
        sl = p / 16;
        ch = (sl + 1) % 32;
        return st * 32 + ch;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (pos %0d)", tag, act, exp, pos);
        end
    endtask

    task automatic fill(input int kind);
        for (int i = 0; i < NLOC; i++) begin
            case (kind)
                0: mem[i] = 1'b0;
                1: mem[i] = 1'b1;
                2: mem[i] = (i / 32) % 2 == 1;
                default: mem[i] = $urandom % 2 == 1;
            endcase
        end
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic step(input bit pulse);
        logic exp_ctrl;
        frame_i = pulse;
        exp_ctrl = synced ? mem[addr_of(pos)] : 1'b0;
        @(posedge clk);
        if (pulse) pos = 0;
        else if (synced) pos = (pos + 1) % NLOC;
        if (pulse) synced = 1;
        @(negedge clk);
        frame_i = 1'b0;
        if (!synced) check("R1", int'(ctrl_o), int'(exp_ctrl));
        else         check("R2", int'(ctrl_o), int'(exp_ctrl));
        if (synced) begin
            if (pulse)                 check("R3", int'(rd_addr_o), 1);
            else if (pos >= 496)       check("R5", int'(rd_addr_o), addr_of(pos));
            else                       check(addr_tag, int'(rd_addr_o), addr_of(pos));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill(1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1", int'(ctrl_o), 0);
        repeat (20) step(1'b0);

        // aligned frame, all ones then zeros
        step(1'b1);
        repeat (511) step(1'b0);
        fill(0);
        addr_tag = "R6";
        repeat (512) step(1'b0);

        // stream-alternating fill, fresh pulse
        fill(2);
        addr_tag = "R4";
        step(1'b1);
        repeat (300) step(1'b0);

        // random fill, mid-frame realignment
        fill(3);
        addr_tag = "R7";
        step(1'b1);
        repeat (600) step(1'b0);

        addr_tag = "R4";
        for (int f = 0; f < 4; f++) begin
            int mid;
            fill(3);
            step(1'b1);
            mid = 1 + ($urandom % 510);
            repeat (mid) step(1'b0);
            addr_tag = "R7";
            step(1'b1);
            repeat (512) step(1'b0);
            addr_tag = "R4";
        end

        // directed: location 0 at position 496, location 32 at 497 (R5)
        fill(0);
        mem[0] = 1'b1;
        mem[32] = 1'b1;
        step(1'b1);
        repeat (496) step(1'b0);
        check("R5", int'(rd_addr_o), 0);
        step(1'b0);
        check("R5", int'(rd_addr_o), 32);
        check("R5", int'(ctrl_o), 1);
        step(1'b0);
        check("R5", int'(ctrl_o), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule